// File: doc/BRIEF.md
# Switch-Level MOS Strength Evaluator

This block turns one MOS switch into a logic element that carries drive strength along with the four-state logic value. A data input arrives as a value and a 3-bit strength. A gate control input arrives as a value only. A polarity select chooses whether the switch conducts on a high or a low control. A resistive flag makes the switch weaken whatever passes through it. The result is a value, a strength and an ambiguity flag. The flag marks a result that may equally be high impedance, written L (0 or z) or H (1 or z).

When the control is unknown or floating, the switch may or may not conduct. A known 0 or 1 on the data then leaves as an L or H result, and unknown data leaves as x. Strength is weakened on the way through. A plain switch caps supply drive at strong. A resistive switch pulls every level down along a fixed ladder. The evaluation is combinational. The result is captured in one output register that is cleared by a synchronous active-high reset, so a switch-level model built from many of these can be stepped one clock at a time.

Top module: `sw_strength_eval`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become value z (2'b11), strength 0 and ambiguity flag 0.
- R2: With `pol_p`=0 (conducts on high control), a control of 1 (2'b01) passes the data value with the flag 0, and a control of 0 (2'b00) gives value z.
- R3: With `pol_p`=1 (conducts on low control), a control of 0 passes the data value with the flag 0, and a control of 1 gives value z.
- R4: With a control of x (2'b10) or z (2'b11), data 0 gives value 0 with the flag 1 (L), data 1 gives value 1 with the flag 1 (H), and data x (2'b10) gives value x with the flag 0.
- R5: Data of value z gives an output value of z for every control, polarity and mode.
- R6: Whenever the output value is z, the output strength is 0 (high impedance) and the flag is 0.
- R7: With `resist`=0 and a non-z output, supply strength 7 leaves as strong (6), and every other strength from 0 to 6 leaves unchanged.
- R8: With `resist`=1 and a non-z output, strengths 7 and 6 become 5, 5 becomes 3, 4 and 3 become 2, 2 and 1 become 1, and 0 stays 0.
- R9: The outputs reflect the inputs present at the previous rising clock edge (one cycle of latency).

Value codes are 00 for 0, 01 for 1, 10 for x and 11 for z. The strength codes are 7 supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small and 0 high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_val | input | 2 | Data input logic value |
| dat_str | input | 3 | Data input drive strength |
| ctl_val | input | 2 | Gate control logic value |
| pol_p | input | 1 | 1 selects a switch that conducts on low control; 0 selects one that conducts on high control |
| resist | input | 1 | 1 selects resistive strength reduction |
| out_val | output | 2 | Output logic value (registered) |
| out_str | output | 3 | Output drive strength (registered) |
| out_amb | output | 1 | 1 when the output may also be z (L or H result) |

## Verification
The bench builds the block with the package defaults: 2-bit values and 3-bit strengths. With these widths the whole input space is only 512 points: four data values, eight strengths, four controls, two polarities and two modes. The bench drives every point. It predicts the value, the flag and the strength from the encoded rules, so every L/H case and every step of both strength ladders is reached. A reset is also applied in the middle of the run to confirm that the register returns to high impedance.

// File: rtl/swsim_pkg.sv
package swsim_pkg;

    localparam int VAL_W = 2;
    localparam int STR_W = 3;

    typedef enum logic [VAL_W-1:0] {
        LV_0 = 2'b00,
        LV_1 = 2'b01,
        LV_X = 2'b10,
        LV_Z = 2'b11
    } lval_e;

    typedef logic [STR_W-1:0] str_t;

    localparam str_t STR_SUPPLY = 3'd7;
    localparam str_t STR_STRONG = 3'd6;
    localparam str_t STR_PULL   = 3'd5;
    localparam str_t STR_LARGE  = 3'd4;
    localparam str_t STR_WEAK   = 3'd3;
    localparam str_t STR_MEDIUM = 3'd2;
    localparam str_t STR_SMALL  = 3'd1;
    localparam str_t STR_HIGHZ  = 3'd0;

    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_ON    = 2'd1,
        GATE_AMBIG = 2'd2
    } gate_e;

    typedef struct packed {
        lval_e val;
        str_t  str;
        logic  amb;
    } swout_t;

    localparam swout_t SWOUT_IDLE = '{val: LV_Z, str: STR_HIGHZ, amb: 1'b0};

    // Conduction state from control value and polarity
    function automatic gate_e gate_of(input lval_e ctl, input logic low_on);
        gate_e g;
        case (ctl)
            LV_0:    g = low_on ? GATE_ON  : GATE_OFF;
            LV_1:    g = low_on ? GATE_OFF : GATE_ON;
            default: g = GATE_AMBIG;
        endcase
        return g;
    endfunction

    // Plain switch: supply drive is capped at strong
    function automatic str_t plain_str(input str_t s);
        return (s == STR_SUPPLY) ? STR_STRONG : s;
    endfunction

    // Resistive switch: weaken along a fixed ladder
    function automatic str_t resist_str(input str_t s);
        str_t r;
        case (s)
            STR_SUPPLY, STR_STRONG: r = STR_PULL;
            STR_PULL:               r = STR_WEAK;
            STR_LARGE, STR_WEAK:    r = STR_MEDIUM;
            STR_MEDIUM, STR_SMALL:  r = STR_SMALL;
            default:                r = STR_HIGHZ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/swg_gate_decode.sv
module swg_gate_decode
    import swsim_pkg::*;
(
    input  logic [VAL_W-1:0] ctl_val,
    input  logic             pol_p,
    output gate_e            gate
);
    always_comb begin
        gate = gate_of(lval_e'(ctl_val), pol_p);
    end
endmodule

// File: rtl/swg_value_map.sv
module swg_value_map
    import swsim_pkg::*;
(
    input  logic [VAL_W-1:0] dat_val,
    input  gate_e            gate,
    output lval_e            val,
    output logic             amb
);
    lval_e din;
    assign din = lval_e'(dat_val);

    always_comb begin
        val = LV_Z;
        amb = 1'b0;
        if (din != LV_Z) begin
            case (gate)
                GATE_ON: begin
                    val = din;
                end
                GATE_AMBIG: begin
                    val = din;
                    // a known level may or may not reach the output
                    amb = (din == LV_0) || (din == LV_1);
                end
                default: begin
                    val = LV_Z;
                end
            endcase
        end
    end
endmodule

// File: rtl/swg_strength_path.sv
module swg_strength_path
    import swsim_pkg::*;
#(
    parameter bit RESIST_SUPPORT = 1'b1
) (
    input  logic [STR_W-1:0] dat_str,
    input  logic             resist,
    input  lval_e            val,
    output str_t             str
);
    str_t reduced;

    generate
        if (RESIST_SUPPORT) begin : g_both
            always_comb begin
                reduced = resist ? resist_str(dat_str) : plain_str(dat_str);
            end
        end else begin : g_plain
            logic unused_resist;
            assign unused_resist = resist;
            always_comb begin
                reduced = plain_str(dat_str);
            end
        end
    endgenerate

    always_comb begin
        str = (val == LV_Z) ? STR_HIGHZ : reduced;
    end
endmodule

// File: rtl/sw_strength_eval.sv
module sw_strength_eval
    import swsim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] dat_val,
    input  logic [STR_W-1:0] dat_str,
    input  logic [VAL_W-1:0] ctl_val,
    input  logic             pol_p,
    input  logic             resist,
    output logic [VAL_W-1:0] out_val,
    output logic [STR_W-1:0] out_str,
    output logic             out_amb
);
    gate_e  gate;
    lval_e  nxt_val;
    logic   nxt_amb;
    str_t   nxt_str;
    swout_t res_q;

    swg_gate_decode u_gate (
        .ctl_val (ctl_val),
        .pol_p   (pol_p),
        .gate    (gate)
    );

    swg_value_map u_vmap (
        .dat_val (dat_val),
        .gate    (gate),
        .val     (nxt_val),
        .amb     (nxt_amb)
    );

    swg_strength_path #(.RESIST_SUPPORT(1'b1)) u_spath (
        .dat_str (dat_str),
        .resist  (resist),
        .val     (nxt_val),
        .str     (nxt_str)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= SWOUT_IDLE;
        end else begin
            res_q <= '{val: nxt_val, str: nxt_str, amb: nxt_amb};
        end
    end

    assign out_val = res_q.val;
    assign out_str = res_q.str;
    assign out_amb = res_q.amb;
endmodule

// File: rtl/sw_strength_eval_chk.sv
module sw_strength_eval_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] dat_val,
    input logic [1:0] ctl_val,
    input logic       pol_p,
    input logic       resist,
    input logic [1:0] out_val,
    input logic [2:0] out_str,
    input logic       out_amb
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (out_val == 2'b11 && out_str == 3'd0 && !out_amb)); // R1

    AST_NMOS_OFF: assert property (@(posedge clk) disable iff (rst)
        (!pol_p && ctl_val == 2'b00) |=> (out_val == 2'b11)); // R2

    AST_NMOS_PASS: assert property (@(posedge clk) disable iff (rst)
        (!pol_p && ctl_val == 2'b01 && dat_val != 2'b11)
        |=> (out_val == $past(dat_val) && !out_amb)); // R2

    AST_PMOS_OFF: assert property (@(posedge clk) disable iff (rst)
        (pol_p && ctl_val == 2'b01) |=> (out_val == 2'b11)); // R3

    AST_AMB_KNOWN: assert property (@(posedge clk) disable iff (rst)
        out_amb |-> (out_val[1] == 1'b0)); // R4

    AST_ZDATA_Z: assert property (@(posedge clk) disable iff (rst)
        (dat_val == 2'b11) |=> (out_val == 2'b11)); // R5

    AST_Z_HIGHZ: assert property (@(posedge clk) disable iff (rst)
        (out_val == 2'b11) |-> (out_str == 3'd0 && !out_amb)); // R6

    AST_NO_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        out_str != 3'd7); // R7

    AST_RES_CAP: assert property (@(posedge clk) disable iff (rst)
        resist |=> (out_str <= 3'd5)); // R8
endmodule

bind sw_strength_eval sw_strength_eval_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .dat_val (dat_val),
    .ctl_val (ctl_val),
    .pol_p   (pol_p),
    .resist  (resist),
    .out_val (out_val),
    .out_str (out_str),
    .out_amb (out_amb)
);

// File: tb/sw_strength_eval_bench.sv
module sw_strength_eval_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dat_val = 2'b11;
    logic [2:0] dat_str = 3'd0;
    logic [1:0] ctl_val = 2'b00;
    logic       pol_p = 1'b0;
    logic       resist = 1'b0;
    logic [1:0] out_val;
    logic [2:0] out_str;
    logic       out_amb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sw_strength_eval u_sw_strength_eval (
        .clk     (clk),
        .rst     (rst),
        .dat_val (dat_val),
        .dat_str (dat_str),
        .ctl_val (ctl_val),
        .pol_p   (pol_p),
        .resist  (resist),
        .out_val (out_val),
        .out_str (out_str),
        .out_amb (out_amb)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (d=%0d s=%0d c=%0d p=%0d r=%0d)",
                     req, act, exp, dat_val, dat_str, ctl_val, pol_p, resist);
        end
    endtask

    task automatic check_idle(input string req);
        check(req, int'(out_val), 3);
        check(req, int'(out_str), 0);
        check(req, int'(out_amb), 0);
    endtask

    // Expected strength from the ladders of R7 and R8
    function automatic int exp_strength(input int s, input bit r);
        if (!r) return (s == 7) ? 6 : s;
        if (s >= 6) return 5;
        if (s == 5) return 3;
        if (s >= 3) return 2;
        if (s >= 1) return 1;
        return 0;
    endfunction

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check_idle("R1");
        rst = 1'b0;

        for (int r = 0; r < 2; r++) begin
            for (int p = 0; p < 2; p++) begin
                for (int c = 0; c < 4; c++) begin
                    for (int d = 0; d < 4; d++) begin
                        for (int s = 0; s < 8; s++) begin
                            int ev, ea, es;
                            bit on, off;
                            string vtag, stag;
                            dat_val = 2'(d); dat_str = 3'(s); ctl_val = 2'(c);
                            pol_p = p[0]; resist = r[0];
                            on  = (p == 0) ? (c == 1) : (c == 0);
                            off = (p == 0) ? (c == 0) : (c == 1);
                            if (d == 3) begin
                                ev = 3; ea = 0; vtag = "R5";
                            end else if (off) begin
                                ev = 3; ea = 0; vtag = (p == 0) ? "R2" : "R3";
                            end else if (on) begin
                                ev = d; ea = 0; vtag = (p == 0) ? "R2" : "R3";
                            end else begin
                                ev = d; ea = (d <= 1) ? 1 : 0; vtag = "R4";
                            end
                            if (ev == 3) begin
                                es = 0; stag = "R6";
                            end else begin
                                es = exp_strength(s, r[0]);
                                stag = (r == 0) ? "R7" : "R8";
                            end
                            // R9: result registered on the next rising edge
                            @(negedge clk);
                            check(vtag, int'(out_val), ev);
                            check(vtag, int'(out_amb), ea);
                            check(stag, int'(out_str), es);
                        end
                    end
                end
            end
        end

        // R9: one-cycle latency, and R1 with a driving input held
        dat_val = 2'b01; dat_str = 3'd7; ctl_val = 2'b01; pol_p = 1'b0; resist = 1'b0;
        @(negedge clk);
        check("R9", int'(out_val), 1);
        check("R9", int'(out_str), 6);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        @(negedge clk);
        check("R9", int'(out_val), 1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule